// File: doc/BRIEF.md
# Status Byte and Service Request Generator

This block assembles an 8-bit status byte from summary flags supplied by the status groups and from a flag that is high while an outgoing message queue is not empty. A host-writable enable mask selects which status bits may ask for service. From that selection the block forms a live master summary bit (MSS). It also keeps a latched request-service bit, which drives an active-high service request line.

Two read paths return the byte one cycle after the request. A status query reports the live MSS in bit 6 and leaves all state as it was. A serial poll reports the latched request-service bit in bit 6 and then clears that bit. The latched bit sets only on a rising edge of MSS. While MSS stays high, a poll therefore ends the request until MSS falls and rises again.

Top module: `status_srq`

## Requirements
- R1: During reset and on the first cycle after it, `srq_o` and `rd_valid_o` are 0. The enable mask resets to 0.
- R2: The status byte holds `aux_sum_i[2:0]` in bits 2:0, `ques_sum_i` in bit 3, `queue_nonempty_i` in bit 4, `evt_sum_i` in bit 5 and `oper_sum_i` in bit 7. Bit 6 carries the read-path-dependent summary.
- R3: MSS is combinational and unlatched. It is 1 exactly when some status byte bit other than bit 6 is 1 and its enable mask bit is also 1.
- R4: A mask written with `sre_we_i` takes effect from the next cycle. Mask bit 6 has no effect on MSS.
- R5: When MSS is 1 in a cycle and was 0 in the previous cycle, the request-service bit is set at the next clock edge. `srq_o` then reads 1.
- R6: A status query (`qry_i`) gives `rd_valid_o`=1 on the next cycle. `rd_data_o` holds the status byte as it was in the request cycle, with MSS in bit 6, and `srq_o` is not changed.
- R7: A serial poll (`poll_i`) gives `rd_valid_o`=1 on the next cycle. `rd_data_o` holds the status byte with the request-service bit from the request cycle in bit 6. The request-service bit is cleared.
- R8: After a poll clears the request-service bit, it stays clear while MSS stays high. It sets again only after MSS falls to 0 and then rises.
- R9: If a poll and an MSS rising edge fall in the same cycle, the set wins and the poll returns the old bit. If a poll and a query fall in the same cycle, the poll's response is returned.
- R10: `srq_o` equals the request-service bit. It goes low on the cycle after a poll that clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_sum_i | input | 3 | Auxiliary group summaries, status bits 2:0 |
| ques_sum_i | input | 1 | Questionable-status summary, bit 3 |
| evt_sum_i | input | 1 | Standard-event summary, bit 5 |
| oper_sum_i | input | 1 | Operation-status summary, bit 7 |
| queue_nonempty_i | input | 1 | Message queue holds at least one byte, bit 4 |
| sre_we_i | input | 1 | Write strobe for the enable mask |
| sre_wdata_i | input | 8 | New enable mask value |
| qry_i | input | 1 | Non-destructive status query request |
| poll_i | input | 1 | Serial poll request |
| rd_valid_o | output | 1 | Read response valid, one cycle after a request |
| rd_data_o | output | 8 | Read response byte |
| srq_o | output | 1 | Service request line, active high |

## Verification
The bench targets a poll that arrives while MSS is still high. A design that sets the request bit on level rather than edge would raise `srq_o` again at once. It drives a poll together with an MSS rise; a design that lets the clear win would drop a fresh request. It sets only mask bit 6 with every input high: a design that does not mask that bit would raise MSS from its own position. It compares bit 6 across both read paths. A swapped read-path mux would report the latched bit on queries, and a query that clears state would drop `srq_o`.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_W     = 8;
    localparam int AUX_W    = 3;
    localparam int QUES_BIT = 3;
    localparam int MAV_BIT  = 4;
    localparam int ESB_BIT  = 5;
    localparam int MSS_BIT  = 6;
    localparam int OPER_BIT = 7;

    localparam logic [SB_W-1:0] SUM_MASK = ~(SB_W'(1) << MSS_BIT);

    typedef struct packed {
        logic             oper;
        logic             sum6;
        logic             esb;
        logic             mav;
        logic             ques;
        logic [AUX_W-1:0] aux;
    } stb_t;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_QUERY = 2'd1,
        RD_POLL  = 2'd2
    } rd_kind_e;

    function automatic logic [SB_W-1:0] put_bit6(stb_t s, logic v);
        stb_t r;
        r      = s;
        r.sum6 = v;
        return r;
    endfunction
endpackage

// File: rtl/sb_summary.sv
module sb_summary
    import sb_pkg::*;
(
    input  logic [AUX_W-1:0] aux_i,
    input  logic             ques_i,
    input  logic             mav_i,
    input  logic             esb_i,
    input  logic             oper_i,
    input  logic [SB_W-1:0]  mask_i,
    output stb_t             stb_o,
    output logic             mss_o
);
    stb_t st;

    always_comb begin
        st.aux  = aux_i;
        st.ques = ques_i;
        st.mav  = mav_i;
        st.esb  = esb_i;
        st.sum6 = 1'b0;
        st.oper = oper_i;
    end

    assign stb_o = st;
    assign mss_o = |(st & mask_i & SUM_MASK);

    // Tie-out of the byte layout (R2): each input must land on its own bit.
    always_comb begin
        a_layout_r2: assert (stb_o[QUES_BIT] == ques_i && stb_o[MAV_BIT] == mav_i &&
                             stb_o[ESB_BIT] == esb_i && stb_o[OPER_BIT] == oper_i);
    end
endmodule

// File: rtl/sb_rqs_latch.sv
module sb_rqs_latch (
    input  logic clk,
    input  logic rst,
    input  logic mss_i,
    input  logic poll_i,
    output logic rqs_o,
    output logic rise_o
);
    logic mss_q;
    logic rqs_q;

    assign rise_o = mss_i & ~mss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mss_q <= 1'b0;
            rqs_q <= 1'b0;
        end else begin
            mss_q <= mss_i;
            if (rise_o)
                rqs_q <= 1'b1;
            else if (poll_i)
                rqs_q <= 1'b0;
        end
    end

    assign rqs_o = rqs_q;

    p_rise_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (mss_i && !mss_q) |=> rqs_o);

    p_rise_needs_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!rqs_o && !mss_i) |=> !rqs_o);
endmodule

// File: rtl/sb_read_port.sv
module sb_read_port
    import sb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            qry_i,
    input  logic            poll_i,
    input  stb_t            stb_i,
    input  logic            mss_i,
    input  logic            rqs_i,
    output logic            valid_o,
    output logic [SB_W-1:0] data_o
);
    rd_kind_e kind;

    always_comb begin
        if (poll_i)
            kind = RD_POLL;
        else if (qry_i)
            kind = RD_QUERY;
        else
            kind = RD_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= (kind != RD_NONE);
            case (kind)
                RD_POLL:  data_o <= put_bit6(stb_i, rqs_i);
                RD_QUERY: data_o <= put_bit6(stb_i, mss_i);
                default:  data_o <= data_o;
            endcase
        end
    end

    p_rd_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (qry_i || poll_i) |=> valid_o);

    p_rd_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !(qry_i || poll_i) |=> !valid_o);
endmodule

// File: rtl/status_srq.sv
module status_srq
    import sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AUX_W-1:0] aux_sum_i,
    input  logic             ques_sum_i,
    input  logic             evt_sum_i,
    input  logic             oper_sum_i,
    input  logic             queue_nonempty_i,
    input  logic             sre_we_i,
    input  logic [SB_W-1:0]  sre_wdata_i,
    input  logic             qry_i,
    input  logic             poll_i,
    output logic             rd_valid_o,
    output logic [SB_W-1:0]  rd_data_o,
    output logic             srq_o
);
    logic [SB_W-1:0] sre_q;
    stb_t            stb;
    logic            mss;
    logic            rqs;
    logic            rise;

    always_ff @(posedge clk) begin
        if (rst)
            sre_q <= '0;
        else if (sre_we_i)
            sre_q <= sre_wdata_i;
    end

    sb_summary u_sum (
        .aux_i  (aux_sum_i),
        .ques_i (ques_sum_i),
        .mav_i  (queue_nonempty_i),
        .esb_i  (evt_sum_i),
        .oper_i (oper_sum_i),
        .mask_i (sre_q),
        .stb_o  (stb),
        .mss_o  (mss)
    );

    sb_rqs_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .mss_i  (mss),
        .poll_i (poll_i),
        .rqs_o  (rqs),
        .rise_o (rise)
    );

    sb_read_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .qry_i   (qry_i),
        .poll_i  (poll_i),
        .stb_i   (stb),
        .mss_i   (mss),
        .rqs_i   (rqs),
        .valid_o (rd_valid_o),
        .data_o  (rd_data_o)
    );

    assign srq_o = rqs;

    p_poll_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (poll_i && !rise) |=> !srq_o);

    p_query_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (qry_i && !poll_i && srq_o) |=> srq_o);

    p_poll_bit6_r7: assert property (@(posedge clk) disable iff (rst)
        poll_i |=> (rd_data_o[MSS_BIT] == $past(srq_o)));

    p_query_bit6_r6: assert property (@(posedge clk) disable iff (rst)
        (qry_i && !poll_i) |=> (rd_data_o[MSS_BIT] == $past(mss)));

    p_mask_bit6_r4: assert property (@(posedge clk) disable iff (rst)
        ((sre_q & SUM_MASK) == '0) |-> !mss);
endmodule

// File: tb/test_status_srq.sv
module test_status_srq;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] aux;
    logic       ques, evt, oper, qne;
    logic       we;
    logic [7:0] wdata;
    logic       qry, poll;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       srq;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic [7:0] m_en;
    logic       m_rqs;
    logic       m_prev;

    always #10 clk = ~clk;

    status_srq i_status_srq (
        .clk(clk), .rst(rst), .aux_sum_i(aux), .ques_sum_i(ques),
        .evt_sum_i(evt), .oper_sum_i(oper), .queue_nonempty_i(qne),
        .sre_we_i(we), .sre_wdata_i(wdata), .qry_i(qry), .poll_i(poll),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .srq_o(srq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Reference model, updated from the requirements at each rising edge.
    always @(posedge clk) begin
        logic [7:0] sb;
        logic       ms;
        if (rst) begin
            m_en = 8'h00; m_rqs = 1'b0; m_prev = 1'b0;
        end else begin
            sb = {oper, 1'b0, evt, qne, ques, aux};          // R2 layout
            ms = |(sb & m_en & 8'hBF);                       // R3, R4
            if (poll) begin
                exp_q.push_back({sb[7], m_rqs, sb[5:0]});    // R7, R9
                tag_q.push_back("R7 poll byte");
            end else if (qry) begin
                exp_q.push_back({sb[7], ms, sb[5:0]});       // R6
                tag_q.push_back("R6 query byte");
            end
            if (ms && !m_prev) m_rqs = 1'b1;                 // R5
            else if (poll)     m_rqs = 1'b0;                 // R8
            m_prev = ms;
            if (we) m_en = wdata;
        end
    end

    // Monitor: pops expected items as responses appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected response", 8'h01, 8'h00);
                end else begin
                    check(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end else if (exp_q.size() != 0) begin
                check("R7 missing response", 8'h00, 8'h01);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            check("R10 srq tracks request bit", {7'd0, srq}, {7'd0, m_rqs});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic q, input logic p);
        @(negedge clk); qry = q; poll = p;
        @(negedge clk); qry = 1'b0; poll = 1'b0;
    endtask

    task automatic set_mask(input logic [7:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; aux = '0; ques = 0; evt = 0; oper = 0; qne = 0;
        we = 0; wdata = '0; qry = 0; poll = 0;
        repeat (3) @(negedge clk);
        check("R1 srq in reset", {7'd0, srq}, 8'h00);
        check("R1 valid in reset", {7'd0, rd_valid}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 srq after reset", {7'd0, srq}, 8'h00);

        // R2: layout with mask zero, MSS must be 0.
        aux = 3'b101; ques = 1; evt = 1;
        pulse(1, 0);
        check("R2 byte layout", rd_data, 8'h2D);

        // R5: enable questionable bit, MSS rises.
        set_mask(8'h08);
        @(negedge clk);
        check("R5 srq after mss rise", {7'd0, srq}, 8'h01);

        // R6: query reports live MSS and keeps srq.
        pulse(1, 0);
        check("R6 query bit6 is mss", {7'd0, rd_data[6]}, 8'h01);
        check("R6 query keeps srq", {7'd0, srq}, 8'h01);

        // R7 and R10: poll returns 1 then clears.
        pulse(0, 1);
        check("R7 poll bit6", {7'd0, rd_data[6]}, 8'h01);
        check("R10 srq low after poll", {7'd0, srq}, 8'h00);

        // R8: MSS stays high, no re-set.
        cyc(4);
        check("R8 no re-set while mss high", {7'd0, srq}, 8'h00);
        pulse(0, 1);
        check("R8 second poll bit6", {7'd0, rd_data[6]}, 8'h00);
        @(negedge clk); ques = 0;
        @(negedge clk); ques = 1;
        @(negedge clk);
        check("R8 re-set after fall and rise", {7'd0, srq}, 8'h01);

        // R4: only mask bit 6 with all inputs high gives no MSS.
        pulse(0, 1);
        aux = 3'b111; evt = 1; oper = 1; qne = 1;
        set_mask(8'h40);
        cyc(2);
        check("R4 mask bit6 ignored srq", {7'd0, srq}, 8'h00);
        pulse(1, 0);
        check("R4 mask bit6 ignored mss", rd_data, 8'hBF);

        // R2: queue flag on bit 4 alone.
        aux = '0; ques = 0; evt = 0; oper = 0; qne = 1;
        set_mask(8'h10);
        @(negedge clk);
        check("R2 queue flag raises srq", {7'd0, srq}, 8'h01);
        pulse(0, 1);

        // R9: poll in the same cycle as an MSS rise; set wins.
        qne = 0;
        cyc(2);
        @(negedge clk); qne = 1; poll = 1;
        @(negedge clk); poll = 0;
        check("R9 poll returns old bit", {7'd0, rd_data[6]}, 8'h00);
        check("R9 set wins over poll", {7'd0, srq}, 8'h01);
        // R9: poll and query together give the poll response and clear.
        pulse(1, 1);
        check("R9 poll priority bit6", {7'd0, rd_data[6]}, 8'h01);
        check("R9 poll priority clears", {7'd0, srq}, 8'h00);

        // Mixed traffic checked by the scoreboard.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            aux  = 3'($urandom);
            ques = 1'($urandom % 3 == 0);
            evt  = 1'($urandom % 3 == 0);
            oper = 1'($urandom % 4 == 0);
            qne  = 1'($urandom % 2);
            we   = 1'($urandom % 16 == 0);
            wdata = 8'($urandom);
            qry  = 1'($urandom % 4 == 0);
            poll = 1'($urandom % 5 == 0);
        end
        @(negedge clk);
        we = 0; qry = 0; poll = 0;
        cyc(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule